// File: doc/BRIEF.md
# Region-based memory protection unit

This block screens every processor access against a table of 32 address ranges. Each range has a start bound, an end bound and four attribute bits. Software edits a shadow table through a small register port. It then moves chosen entries into the active table: it sets bits in a copy mask and issues a copy command. An access presents an address, a type (execute, read or write) and a size. The unit answers one cycle later with pass or abort, plus the cacheable attribute of the range that granted it.

Ranges are compared at 32-byte line granularity. When several ranges cover an address, the lowest entry index decides. An address that no active range covers is judged by a programmable fallback attribute word. A rejected access raises a one-cycle abort pulse with a detailed status word. The unit also records the status word and the faulting address in registers that software can read and clear. A control bit chooses whether the first or the most recent abort is kept.

Register map (byte offsets on `reg_addr`):
- 0x000 control: bit0 blocks direct active-table writes, bit3 enables overlap reporting, bit4 keeps the latest abort, bit5 (write-only action) clears the record.
- 0x004 fallback attributes.
- 0x008 copy mask.
- 0x00C command.
- 0x010 abort status (read-only).
- 0x014 abort address (read-only).
- 0x018 active bitmap (read-only).

The two tables are laid out as follows:
- The shadow table starts at 0x400 and the active table at 0x800.
- Each entry occupies 16 bytes, so entry i sits at base + 16·i.
- Within an entry, the word at +0 holds the start address, +4 the end address and +8 the attributes.

Top module: `region_guard`

## Requirements
- R1: After reset, resp_valid, resp_abort and resp_cache are 0, and the abort status, abort address and active bitmap registers read 0.
- R2: Shadow start and end words are stored at line granularity and read back with bits [4:0] cleared. A table write whose entry index (reg_addr[9:4]) is above 31 is ignored: it changes no entry, including entry index mod 32, and reads back 0.
- R3: Command 2 copies every shadow entry whose copy-mask bit is set into the active table and sets its bit in the active bitmap; unmasked entries are left as they were. Command 1 clears the active bitmap and the copy mask. Command 0 changes nothing.
- R4: An active entry covers an address when the address's line number (addr[31:5]) lies between the start's and the end's line numbers inclusive, so the whole line holding the end address is covered.
- R5: The response appears on the clock edge after acc_valid. The type encoding is 0 execute, 1 read, 2 write, 3 reserved. The access passes only if the deciding attribute bit is set: bit1 for execute, bit2 for read, bit3 for write. Type 3 always aborts. On a pass, resp_cache equals attribute bit0; on an abort it is 0.
- R6: When more than one active entry covers the address, the lowest index decides. Status bit3 (overlap) is set only when control bit3 is 1 and more than one entry matched.
- R7: An address covered by no active entry is judged by the fallback attribute word. Such an abort reports unit 5 and entry index 0.
- R8: On an abort, resp_status carries:
  - bits [2:0]: unit, 4 for an entry and 5 for the fallback;
  - bit3: overlap;
  - bits [8:4]: entry index;
  - bits [17:16]: access type;
  - bits [19:18]: access size;
  - bit21: 1;
  - all other bits: 0.
  On a pass, resp_status is 0.
- R9: On an abort the status word and the full access address are recorded if nothing is recorded yet (unit field 0), or always when control bit4 is 1. Writing control with bit5 set zeroes both records.
- R10: When control bit0 is 1, writes to the active table are ignored. When it is 0, writing an active-table word updates that entry and sets its bitmap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_type | input | 2 | 0 execute, 1 read, 2 write |
| acc_size | input | 2 | Access size code, reported in status |
| resp_valid | output | 1 | Response for the previous cycle's access |
| resp_abort | output | 1 | One-cycle abort pulse |
| resp_cache | output | 1 | Cacheable attribute of a passing access |
| resp_status | output | 32 | Status word of an aborting access |

## Verification
Register writes take effect at the clock edge that samples reg_wr. Reads are combinational, so the bench drives a write on one falling edge and reads the result back on the next falling edge. An access is driven on a falling edge, and its response (resp_valid, resp_abort, resp_cache, resp_status) is due exactly one rising edge later. The bench therefore samples it at the following falling edge. The abort records are updated at that same edge, so they are read back at the next falling edge or later.

// File: rtl/region_guard.sv
module region_guard #(
  parameter int ENTRIES = 32,
  parameter int AW      = 32,
  parameter int LINE_B  = 5,
  parameter int RAW     = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic [1:0]     acc_type,
  input  logic [1:0]     acc_size,
  output logic           resp_valid,
  output logic           resp_abort,
  output logic           resp_cache,
  output logic [31:0]    resp_status
);
  localparam int LW = AW - LINE_B;
  localparam int IW = $clog2(ENTRIES);

  localparam logic [RAW-1:0] A_CFG  = RAW'(12'h000);
  localparam logic [RAW-1:0] A_FB   = RAW'(12'h004);
  localparam logic [RAW-1:0] A_MASK = RAW'(12'h008);
  localparam logic [RAW-1:0] A_CMD  = RAW'(12'h00C);
  localparam logic [RAW-1:0] A_STAT = RAW'(12'h010);
  localparam logic [RAW-1:0] A_ADDR = RAW'(12'h014);
  localparam logic [RAW-1:0] A_MAP  = RAW'(12'h018);

  logic [LW-1:0] sh_lo [ENTRIES];
  logic [LW-1:0] sh_hi [ENTRIES];
  logic [3:0]    sh_at [ENTRIES];
  logic [LW-1:0] act_lo [ENTRIES];
  logic [LW-1:0] act_hi [ENTRIES];
  logic [3:0]    act_at [ENTRIES];
  logic [ENTRIES-1:0] act_map;
  logic [31:0]   cp_mask;
  logic [3:0]    fb_at;
  logic          cfg_block, cfg_all, cfg_last;
  logic [31:0]   ab_stat;
  logic [AW-1:0] ab_addr;

  wire [5:0]    idx6    = reg_addr[9:4];
  wire [1:0]    fld     = reg_addr[3:2];
  wire          idx_ok  = (idx6 < 6'(ENTRIES)) && (reg_addr[1:0] == 2'b00);
  wire          sh_sel  = (reg_addr[RAW-1:10] == (RAW-10)'(1)) && idx_ok;
  wire          act_sel = (reg_addr[RAW-1:10] == (RAW-10)'(2)) && idx_ok;
  wire [LW-1:0] wr_line = reg_wdata[AW-1:LINE_B];
  wire          cmd_wr  = reg_wr && (reg_addr == A_CMD);
  wire          clr_wr  = reg_wr && (reg_addr == A_CFG) && reg_wdata[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        sh_lo[i]  <= '0;
        sh_hi[i]  <= '0;
        sh_at[i]  <= '0;
        act_lo[i] <= '0;
        act_hi[i] <= '0;
        act_at[i] <= '0;
      end
      act_map   <= '0;
      cp_mask   <= '0;
      fb_at     <= '0;
      cfg_block <= 1'b0;
      cfg_all   <= 1'b0;
      cfg_last  <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_CFG) begin
        cfg_block <= reg_wdata[0];
        cfg_all   <= reg_wdata[3];
        cfg_last  <= reg_wdata[4];
      end
      if (reg_addr == A_FB)
        fb_at <= reg_wdata[3:0];
      if (reg_addr == A_MASK)
        cp_mask <= reg_wdata;
      if (cmd_wr && reg_wdata[1:0] == 2'd1) begin
        act_map <= '0;
        cp_mask <= '0;
      end
      for (int i = 0; i < ENTRIES; i++) begin
        if (cmd_wr && reg_wdata[1:0] == 2'd2 && cp_mask[i]) begin
          act_lo[i]  <= sh_lo[i];
          act_hi[i]  <= sh_hi[i];
          act_at[i]  <= sh_at[i];
          act_map[i] <= 1'b1;
        end
        if (sh_sel && idx6 == 6'(i)) begin
          case (fld)
            2'd0:    sh_lo[i] <= wr_line;
            2'd1:    sh_hi[i] <= wr_line;
            2'd2:    sh_at[i] <= reg_wdata[3:0];
            default: ;
          endcase
        end
        if (act_sel && !cfg_block && idx6 == 6'(i) && fld != 2'd3) begin
          case (fld)
            2'd0:    act_lo[i] <= wr_line;
            2'd1:    act_hi[i] <= wr_line;
            default: act_at[i] <= reg_wdata[3:0];
          endcase
          act_map[i] <= 1'b1;
        end
      end
    end
  end

  logic [31:0] tbl_rd;
  always_comb begin
    tbl_rd = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (idx_ok && idx6 == 6'(i)) begin
        if (sh_sel) begin
          case (fld)
            2'd0:    tbl_rd = 32'({sh_lo[i], {LINE_B{1'b0}}});
            2'd1:    tbl_rd = 32'({sh_hi[i], {LINE_B{1'b0}}});
            2'd2:    tbl_rd = {28'd0, sh_at[i]};
            default: tbl_rd = '0;
          endcase
        end else if (act_sel) begin
          case (fld)
            2'd0:    tbl_rd = 32'({act_lo[i], {LINE_B{1'b0}}});
            2'd1:    tbl_rd = 32'({act_hi[i], {LINE_B{1'b0}}});
            2'd2:    tbl_rd = {28'd0, act_at[i]};
            default: tbl_rd = '0;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {27'd0, cfg_last, cfg_all, 2'b00, cfg_block};
      A_FB:    reg_rdata = {28'd0, fb_at};
      A_MASK:  reg_rdata = cp_mask;
      A_STAT:  reg_rdata = ab_stat;
      A_ADDR:  reg_rdata = 32'(ab_addr);
      A_MAP:   reg_rdata = 32'(act_map);
      default: reg_rdata = tbl_rd;
    endcase
  end

  wire [LW-1:0] a_line = acc_addr[AW-1:LINE_B];
  logic [ENTRIES-1:0] hit;
  logic [IW-1:0] win;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      hit[i] = act_map[i] && (a_line >= act_lo[i]) && (a_line <= act_hi[i]);
    win = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit[i]) win = IW'(i);
  end

  wire       any_hit = |hit;
  wire       multi   = (hit & (hit - 1'b1)) != '0;
  wire [3:0] eff_at  = any_hit ? act_at[win] : fb_at;
  logic      perm;

  always_comb begin
    case (acc_type)
      2'd0:    perm = eff_at[1];
      2'd1:    perm = eff_at[2];
      2'd2:    perm = eff_at[3];
      default: perm = 1'b0;
    endcase
  end

  wire        fault    = acc_valid && !perm;
  wire [2:0]  unit     = any_hit ? 3'd4 : 3'd5;
  wire [4:0]  idx_f    = any_hit ? 5'(win) : 5'd0;
  wire [31:0] stat_now = {10'd0, 1'b1, 1'b0, acc_size, acc_type, 7'd0,
                          idx_f, cfg_all && multi, unit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_abort  <= 1'b0;
      resp_cache  <= 1'b0;
      resp_status <= '0;
      ab_stat     <= '0;
      ab_addr     <= '0;
    end else begin
      resp_valid  <= acc_valid;
      resp_abort  <= fault;
      resp_cache  <= acc_valid && perm && eff_at[0];
      resp_status <= fault ? stat_now : '0;
      if (clr_wr) begin
        ab_stat <= '0;
        ab_addr <= '0;
      end else if (fault && (ab_stat[2:0] == 3'd0 || cfg_last)) begin
        ab_stat <= stat_now;
        ab_addr <= acc_addr;
      end
    end
  end
endmodule

module region_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic        acc_valid,
  input logic        resp_valid,
  input logic        resp_abort,
  input logic        resp_cache,
  input logic [31:0] resp_status,
  input logic [31:0] act_map,
  input logic [31:0] ab_stat,
  input logic        cfg_last,
  input logic        cfg_block
);
  p_resp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> resp_valid);
  p_no_resp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !resp_valid && !resp_abort);
  p_abort_no_cache_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_abort |-> !resp_cache);
  p_status_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_abort |-> resp_status[21] && (resp_status[2:0] == 3'd4 || resp_status[2:0] == 3'd5));
  p_pass_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_abort |-> resp_status == 32'd0);
  p_fallback_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_abort && resp_status[2:0] == 3'd5 |-> resp_status[8:3] == 6'd0);
  p_init_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 12'h00C && reg_wdata[1:0] == 2'd1 |=> act_map == 32'd0);
  p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_block && reg_wr && reg_addr[11:10] == 2'b10 |=> $stable(act_map));
  p_keep_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ab_stat[2:0] != 3'd0 && !cfg_last && !reg_wr |=> $stable(ab_stat));
endmodule

bind region_guard region_guard_chk u_chk (.*);

// File: tb/sim_region_guard.sv
`timescale 1ns/1ps
module sim_region_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_type = '0;
  logic [1:0]  acc_size = '0;
  logic        resp_valid, resp_abort, resp_cache;
  logic [31:0] resp_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [11:0] A_CFG = 12'h000, A_FB = 12'h004, A_MASK = 12'h008,
                          A_CMD = 12'h00C, A_STAT = 12'h010, A_ADDR = 12'h014,
                          A_MAP = 12'h018;

  always #10 clk = ~clk;

  region_guard u0 (.*);

  function automatic logic [11:0] sh(input int idx, input int f);
    return 12'(12'h400 + idx * 16 + f * 4);
  endfunction
  function automatic logic [11:0] ac(input int idx, input int f);
    return 12'(12'h800 + idx * 16 + f * 4);
  endfunction
  function automatic logic [31:0] st(input logic [2:0] u, input logic [4:0] ix,
                                     input logic ov, input logic [1:0] ty,
                                     input logic [1:0] sz);
    return (32'd1 << 21) | ({30'd0, sz} << 18) | ({30'd0, ty} << 16) |
           ({27'd0, ix} << 4) | ({31'd0, ov} << 3) | {29'd0, u};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic acc(input string req, input logic [31:0] a, input logic [1:0] ty,
                     input logic [1:0] sz, input logic ab, input logic ca,
                     input logic [31:0] s);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_type = ty; acc_size = sz;
    @(negedge clk);
    acc_valid = 1'b0;
    chk({req, " valid"}, {31'd0, resp_valid}, 32'd1);
    chk({req, " abort"}, {31'd0, resp_abort}, {31'd0, ab});
    chk({req, " cache"}, {31'd0, resp_cache}, {31'd0, ca});
    chk({req, " status"}, resp_status, s);
  endtask

  task automatic t_reset;
    chk("R1 valid", {31'd0, resp_valid}, 32'd0);
    chk("R1 abort", {31'd0, resp_abort}, 32'd0);
    chk("R1 cache", {31'd0, resp_cache}, 32'd0);
    rd_chk("R1 stat", A_STAT, 32'd0);
    rd_chk("R1 addr", A_ADDR, 32'd0);
    rd_chk("R1 map", A_MAP, 32'd0);
  endtask

  task automatic t_shadow;
    wr(sh(3, 0), 32'h1000_0013);
    rd_chk("R2 start aligned", sh(3, 0), 32'h1000_0000);
    wr(sh(40, 0), 32'h7777_7700);
    wr(sh(40, 2), 32'h0000_000F);
    rd_chk("R2 index 40 reads 0", sh(40, 0), 32'd0);
    rd_chk("R2 alias entry 8 start", sh(8, 0), 32'd0);
    rd_chk("R2 alias entry 8 attr", sh(8, 2), 32'd0);
  endtask

  task automatic t_copy;
    wr(sh(0, 0), 32'h0000_1000); wr(sh(0, 1), 32'h0000_1FE4); wr(sh(0, 2), 32'hF);
    wr(sh(1, 0), 32'h0000_3000); wr(sh(1, 1), 32'h0000_30FF); wr(sh(1, 2), 32'h4);
    wr(sh(2, 0), 32'h0000_3000); wr(sh(2, 1), 32'h0000_303F); wr(sh(2, 2), 32'hF);
    wr(A_MASK, 32'h3);
    wr(A_CMD, 32'd2);
    rd_chk("R3 copy map", A_MAP, 32'h3);
    rd_chk("R3 copied end", ac(0, 1), 32'h0000_1FE0);
    rd_chk("R3 unmasked entry2 untouched", ac(2, 2), 32'd0);
    wr(A_CMD, 32'd0);
    rd_chk("R3 nop map", A_MAP, 32'h3);
    rd_chk("R3 nop mask", A_MASK, 32'h3);
  endtask

  task automatic t_match;
    acc("R4 below start -> fallback", 32'h0000_0FFC, 2'd1, 2'd2, 1, 0, st(3'd5, 5'd0, 0, 2'd1, 2'd2));
    acc("R4 start line", 32'h0000_1000, 2'd0, 2'd0, 0, 1, 32'd0);
    acc("R4 end line last byte", 32'h0000_1FFF, 2'd1, 2'd0, 0, 1, 32'd0);
    acc("R4 past end line", 32'h0000_2000, 2'd1, 2'd1, 1, 0, st(3'd5, 5'd0, 0, 2'd1, 2'd1));
    acc("R5 read-only read", 32'h0000_3080, 2'd1, 2'd0, 0, 0, 32'd0);
    acc("R5 read-only write", 32'h0000_3080, 2'd2, 2'd3, 1, 0, st(3'd4, 5'd1, 0, 2'd2, 2'd3));
    acc("R5 read-only exec", 32'h0000_3080, 2'd0, 2'd1, 1, 0, st(3'd4, 5'd1, 0, 2'd0, 2'd1));
    acc("R5 type 3 denied", 32'h0000_1100, 2'd3, 2'd0, 1, 0, st(3'd4, 5'd0, 0, 2'd3, 2'd0));
    wr(A_FB, 32'h5);
    acc("R7 fallback read pass", 32'h0000_8000, 2'd1, 2'd0, 0, 1, 32'd0);
    acc("R7 fallback write abort", 32'h0000_8000, 2'd2, 2'd2, 1, 0, st(3'd5, 5'd0, 0, 2'd2, 2'd2));
  endtask

  task automatic t_overlap;
    wr(A_MASK, 32'h4);
    wr(A_CMD, 32'd2);
    rd_chk("R3 second copy map", A_MAP, 32'h7);
    wr(A_CFG, 32'h0);
    acc("R6 lowest wins no overlap flag", 32'h0000_3020, 2'd2, 2'd0, 1, 0, st(3'd4, 5'd1, 0, 2'd2, 2'd0));
    wr(A_CFG, 32'h8);
    acc("R6 overlap flag", 32'h0000_3020, 2'd2, 2'd0, 1, 0, st(3'd4, 5'd1, 1, 2'd2, 2'd0));
    acc("R6 single match no flag", 32'h0000_3040, 2'd2, 2'd0, 1, 0, st(3'd4, 5'd1, 0, 2'd2, 2'd0));
  endtask

  task automatic t_capture;
    wr(A_CFG, 32'h20);
    rd_chk("R9 clear stat", A_STAT, 32'd0);
    rd_chk("R9 clear addr", A_ADDR, 32'd0);
    acc("R9 first abort", 32'h0000_3084, 2'd2, 2'd1, 1, 0, st(3'd4, 5'd1, 0, 2'd2, 2'd1));
    acc("R9 second abort", 32'h0000_9004, 2'd0, 2'd0, 1, 0, st(3'd5, 5'd0, 0, 2'd0, 2'd0));
    rd_chk("R9 keeps first stat", A_STAT, st(3'd4, 5'd1, 0, 2'd2, 2'd1));
    rd_chk("R9 keeps first addr", A_ADDR, 32'h0000_3084);
    wr(A_CFG, 32'h10);
    acc("R9 third abort", 32'h0000_9008, 2'd0, 2'd2, 1, 0, st(3'd5, 5'd0, 0, 2'd0, 2'd2));
    rd_chk("R9 keeps last stat", A_STAT, st(3'd5, 5'd0, 0, 2'd0, 2'd2));
    rd_chk("R9 keeps last addr", A_ADDR, 32'h0000_9008);
    wr(A_CFG, 32'h20);
    rd_chk("R9 cleared again", A_STAT, 32'd0);
  endtask

  task automatic t_block;
    wr(A_CFG, 32'h1);
    wr(ac(5, 2), 32'h8);
    rd_chk("R10 blocked map", A_MAP, 32'h7);
    rd_chk("R10 blocked attr", ac(5, 2), 32'd0);
    wr(A_CFG, 32'h0);
    wr(ac(5, 0), 32'h0000_5000); wr(ac(5, 1), 32'h0000_50FF); wr(ac(5, 2), 32'h8);
    rd_chk("R10 direct map", A_MAP, 32'h27);
    acc("R10 direct entry write pass", 32'h0000_5010, 2'd2, 2'd0, 0, 0, 32'd0);
    acc("R10 direct entry read abort", 32'h0000_5010, 2'd1, 2'd0, 1, 0, st(3'd4, 5'd5, 0, 2'd1, 2'd0));
  endtask

  task automatic t_init;
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_CMD, 32'd1);
    rd_chk("R3 init map", A_MAP, 32'd0);
    rd_chk("R3 init mask", A_MASK, 32'd0);
    acc("R3 after init uses fallback", 32'h0000_1000, 2'd0, 2'd0, 1, 0, st(3'd5, 5'd0, 0, 2'd0, 2'd0));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_copy();
    t_match();
    t_overlap();
    t_capture();
    t_block();
    t_init();
    finish_run();
  end
endmodule